// File: doc/BRIEF.md
# Trigger Data Frame Transmitter

This block is the word source on the front-end side of a one-way trigger data link. On every clock of the 50 MHz word clock it emits one 18-bit word, and the words form an endless train of 20-word frames. Each word carries three fast trigger bits taken from the current sample: the discriminator state, an error indication and a pile-up indication. The remaining field of each word carries a flag, a fixed 4-bit Gray-coded word tag and a slow byte. The slow bytes carry identification bytes in every frame. The nine payload bytes (five hit-pattern bytes, two timestamp bytes and two energy bytes) are carried only in the frame that answers a Demand Slow Data command.

Command decoding happens upstream. The block receives one-cycle strobes for the Sync and Demand Slow Data commands on the edge on which they are decoded. It starts the answering frame a fixed number of clocks later, abandoning the frame in progress. Sync starts a frame without payload, anchors the frame phase and releases the power-up error indication. A Demand Slow Data command that arrives off the frame grid set by the latest Sync raises a sticky error that only reset clears. Bit 0 of each word is left at 0 for a downstream polarity/balance encoder, which aligns to frames using the frame-start pulse and the word index outputs.

Payload bytes enter on a valid/ready byte stream. `pay_ready` is high only in the cycles that load a payload word, and a byte is taken on each edge where `pay_valid` and `pay_ready` are both high. The source is never held off for longer than one frame. If it has nothing to offer, the word goes out with the flag set and a zero byte, and no byte is consumed. The output side has no back-pressure: the link takes one word on every clock.

Top module: `trig_frame_tx`

## Requirements
- R1: While `rst_n` is low, `tx_word`, `tx_sof`, `tx_widx` and `pay_ready` are all 0. The first rising edge after release loads word index 0 with `tx_sof` high.
- R2: `tx_widx` advances by one on each clock from 0 to 19 and wraps to 0, except where R8 restarts the frame. `tx_sof` is high exactly when `tx_widx` is 0. Bits 17 and 0 of `tx_word` are always 0.
- R3: Bits 12:9 carry the word tag. For indices 0 to 13 the tags are, in order, 0000, 0010, 0011, 1011, 1001, 1101, 1111, 1110, 0110, 0111, 0101, 0100, 1100, 1000. For indices 14 to 19 the tag is 0000.
- R4: Bit 16 is `disc_in` and bit 14 is `pileup_in`, both sampled on the edge that loads the word.
- R5: In every frame, indices 0, 1 and 2 have bit 13 (flag) = 1. Their bits 8:1 are `id_byte`, `bufcnt_byte` and `status_byte` respectively, sampled on the loading edge.
- R6: In a frame started by a Demand Slow Data strobe, indices 3 to 11 have flag = 1. `pay_ready` is high in the cycle before each of those words loads. Bits 8:1 are `pay_data` when `pay_valid` is high and 00 otherwise. A byte is consumed only on an edge where `pay_valid` and `pay_ready` are both high.
- R7: Every other word (indices 3 to 11 of other frames, and indices 12 to 19 of every frame) has flag = 0 and bits 8:1 equal to `fill_byte`, with `pay_ready` low.
- R8: A strobe sampled on edge E makes the edge E+5 load word index 0 of a new frame, abandoning the current one. If both strobes are sampled on the same edge, the new frame follows the Sync rules.
- R9: A Sync-started frame carries no payload. The power-up error indication holds bit 15 at 1 from reset until the first word of the first Sync-started frame; that word and all later words are free of it.
- R10: A Demand Slow Data strobe is in time only if sampled on the same edge as a Sync strobe, or a whole multiple of 20 edges after the latest Sync strobe. Otherwise, including before any Sync, bit 15 is 1 from the next loaded word onward until reset.
- R11: Bit 15 is the OR of `fault_in` (sampled on the loading edge), the power-up indication of R9 and the sticky error of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_stb | input | 1 | One-cycle strobe: Sync command decoded |
| dsd_stb | input | 1 | One-cycle strobe: Demand Slow Data command decoded |
| disc_in | input | 1 | Current discriminator sample |
| pileup_in | input | 1 | Current pile-up indication |
| fault_in | input | 1 | Internal fault indication from the front end |
| id_byte | input | 8 | Crystal identification byte |
| bufcnt_byte | input | 8 | Buffer count byte |
| status_byte | input | 8 | Status byte |
| fill_byte | input | 8 | Filler/balance byte for non-payload words |
| pay_valid | input | 1 | Payload stream: byte offered |
| pay_ready | output | 1 | Payload stream: byte taken on this edge if valid |
| pay_data | input | 8 | Payload stream byte, sent in stream order |
| tx_word | output | 18 | Link word before polarity encoding |
| tx_sof | output | 1 | High with word index 0 |
| tx_widx | output | 5 | Index of the word on `tx_word` |

## Verification
A wrong word index or a lost restart is visible on the very next word: the tag bits, the flag and `tx_widx` no longer match the frame position expected from the strobe history, and `tx_sof` lands on the wrong cycle. A wrong slow/fast frame decision shows within at most four cycles of the frame start, because the flag on index 3 and `pay_ready` diverge there. A wrong phase or error state shows as bit 15 in the word loaded right after the offending strobe, and the bit then stays wrong in every word until reset. Because the bench compares every field of every word against its own model, the first bad cycle is reported.

// File: rtl/trig_tx_pkg.sv
package trig_tx_pkg;

  localparam int LINK_W    = 18;
  localparam int SLOW_W    = 8;
  localparam int HEAD_LAST = 2;   // indices 0..2 carry identification bytes
  localparam int PAY_FIRST = 3;   // first payload index
  localparam int PAY_WORDS = 9;   // payload bytes per answering frame
  localparam int TAG_WORDS = 14;  // indices that carry a non-zero-position tag

  typedef struct packed {
    logic              guard;
    logic              disc;
    logic              err;
    logic              pileup;
    logic              flag;
    logic [3:0]        tag;
    logic [SLOW_W-1:0] slow;
    logic              pol;
  } link_word_t;

  // Fixed Gray-coded tag per word position; positions past the tagged range send 0.
  function automatic logic [3:0] word_tag(input int unsigned idx);
    case (idx)
      0:       word_tag = 4'b0000;
      1:       word_tag = 4'b0010;
      2:       word_tag = 4'b0011;
      3:       word_tag = 4'b1011;
      4:       word_tag = 4'b1001;
      5:       word_tag = 4'b1101;
      6:       word_tag = 4'b1111;
      7:       word_tag = 4'b1110;
      8:       word_tag = 4'b0110;
      9:       word_tag = 4'b0111;
      10:      word_tag = 4'b0101;
      11:      word_tag = 4'b0100;
      12:      word_tag = 4'b1100;
      13:      word_tag = 4'b1000;
      default: word_tag = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/tft_cmd_align.sv
module tft_cmd_align #(
  parameter int FRAME_WORDS = 20,
  parameter int RESP_LAT    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_stb,
  input  logic dsd_stb,
  output logic restart_sync,
  output logic restart_dsd,
  output logic err_init,
  output logic err_late
);
  localparam int PH_W = $clog2(FRAME_WORDS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_WORDS - 1);
  localparam logic [PH_W-1:0] PH_NEXT = PH_W'(1 % FRAME_WORDS);

  logic [1:0] stb_in;
  logic [1:0] stb_out;
  assign stb_in = {dsd_stb, sync_stb};

  // One delay line per command kind: the strobe re-emerges one cycle before
  // the edge that must load word 0 of the answering frame.
  for (genvar g = 0; g < 2; g++) begin : g_dly
    logic [RESP_LAT-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[RESP_LAT-2:0], stb_in[g]};
    end
    assign stb_out[g] = sh[RESP_LAT-1];
  end

  assign restart_sync = stb_out[0];
  assign restart_dsd  = stb_out[1];

  // Frame phase counted in the strobe domain, anchored by each Sync strobe.
  logic [PH_W-1:0] ph_q;
  logic            synced_q;
  logic            in_time;
  assign in_time = sync_stb | (synced_q & (ph_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      synced_q <= 1'b0;
      err_late <= 1'b0;
      err_init <= 1'b1;
    end else begin
      if (sync_stb) begin
        ph_q     <= PH_NEXT;
        synced_q <= 1'b1;
      end else begin
        ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
      end
      if (dsd_stb && !in_time) err_late <= 1'b1;
      if (restart_sync)        err_init <= 1'b0;
    end
  end
endmodule

// File: rtl/tft_word_seq.sv
module tft_word_seq #(
  parameter  int FRAME_WORDS = 20,
  localparam int IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_sync,
  input  logic             restart_dsd,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_slow
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_WORDS - 1);

  logic [IDX_W-1:0] next_q;
  logic             slow_q;
  logic             restart;
  assign restart = restart_sync | restart_dsd;

  // Index and frame kind of the word being built in this cycle.
  always_comb begin
    if (restart) begin
      cur_idx  = '0;
      cur_slow = restart_dsd & ~restart_sync;
    end else begin
      cur_idx  = next_q;
      cur_slow = (next_q == '0) ? 1'b0 : slow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      slow_q <= 1'b0;
    end else begin
      next_q <= (cur_idx == IDX_LAST) ? '0 : cur_idx + IDX_W'(1);
      slow_q <= cur_slow;
    end
  end
endmodule

// File: rtl/tft_word_build.sv
module tft_word_build
  import trig_tx_pkg::*;
#(
  parameter  int FRAME_WORDS = 20,
  localparam int IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic              cur_slow,
  input  logic              disc,
  input  logic              err,
  input  logic              pileup,
  input  logic [SLOW_W-1:0] id_byte,
  input  logic [SLOW_W-1:0] bufcnt_byte,
  input  logic [SLOW_W-1:0] status_byte,
  input  logic [SLOW_W-1:0] fill_byte,
  input  logic              pay_valid,
  input  logic [SLOW_W-1:0] pay_data,
  output link_word_t        word,
  output logic              pay_ready
);
  localparam logic [IDX_W-1:0] IDX_ID  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_BUF = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_ST  = IDX_W'(HEAD_LAST);
  localparam logic [IDX_W-1:0] PAY_LO  = IDX_W'(PAY_FIRST);
  localparam logic [IDX_W-1:0] PAY_HI  = IDX_W'(PAY_FIRST + PAY_WORDS - 1);

  logic in_pay;
  assign in_pay    = cur_slow && (cur_idx >= PAY_LO) && (cur_idx <= PAY_HI);
  assign pay_ready = in_pay;

  always_comb begin
    word        = '0;
    word.disc   = disc;
    word.err    = err;
    word.pileup = pileup;
    word.tag    = word_tag(int'(cur_idx));
    if (cur_idx == IDX_ID) begin
      word.flag = 1'b1;
      word.slow = id_byte;
    end else if (cur_idx == IDX_BUF) begin
      word.flag = 1'b1;
      word.slow = bufcnt_byte;
    end else if (cur_idx == IDX_ST) begin
      word.flag = 1'b1;
      word.slow = status_byte;
    end else if (in_pay) begin
      word.flag = 1'b1;
      word.slow = pay_valid ? pay_data : '0;
    end else begin
      word.flag = 1'b0;
      word.slow = fill_byte;
    end
  end
endmodule

// File: rtl/trig_frame_tx.sv
module trig_frame_tx
  import trig_tx_pkg::*;
#(
  parameter  int FRAME_WORDS = 20,
  parameter  int RESP_LAT    = 5,
  localparam int IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_stb,
  input  logic              dsd_stb,
  input  logic              disc_in,
  input  logic              pileup_in,
  input  logic              fault_in,
  input  logic [SLOW_W-1:0] id_byte,
  input  logic [SLOW_W-1:0] bufcnt_byte,
  input  logic [SLOW_W-1:0] status_byte,
  input  logic [SLOW_W-1:0] fill_byte,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [SLOW_W-1:0] pay_data,
  output logic [LINK_W-1:0] tx_word,
  output logic              tx_sof,
  output logic [IDX_W-1:0]  tx_widx
);
  logic             restart_sync, restart_dsd, err_init, err_late;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_slow;
  logic             err_bit;
  link_word_t       word;

  tft_cmd_align #(.FRAME_WORDS(FRAME_WORDS), .RESP_LAT(RESP_LAT)) u_align (
    .clk(clk), .rst_n(rst_n), .sync_stb(sync_stb), .dsd_stb(dsd_stb),
    .restart_sync(restart_sync), .restart_dsd(restart_dsd),
    .err_init(err_init), .err_late(err_late)
  );

  tft_word_seq #(.FRAME_WORDS(FRAME_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart_sync(restart_sync),
    .restart_dsd(restart_dsd), .cur_idx(cur_idx), .cur_slow(cur_slow)
  );

  // The power-up indication drops on the first word of a Sync-started frame.
  assign err_bit = fault_in | err_late | (err_init & ~restart_sync);

  tft_word_build #(.FRAME_WORDS(FRAME_WORDS)) u_build (
    .cur_idx(cur_idx), .cur_slow(cur_slow), .disc(disc_in), .err(err_bit),
    .pileup(pileup_in), .id_byte(id_byte), .bufcnt_byte(bufcnt_byte),
    .status_byte(status_byte), .fill_byte(fill_byte), .pay_valid(pay_valid),
    .pay_data(pay_data), .word(word), .pay_ready(pay_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_sof  <= 1'b0;
      tx_widx <= '0;
    end else begin
      tx_word <= word;
      tx_sof  <= (cur_idx == '0);
      tx_widx <= cur_idx;
    end
  end
endmodule

// File: rtl/trig_frame_tx_chk.sv
module trig_frame_tx_chk #(
  parameter  int FRAME_WORDS = 20,
  localparam int IDX_W       = $clog2(FRAME_WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pay_ready,
  input logic             tx_guard,
  input logic             tx_pol,
  input logic             tx_flag,
  input logic [3:0]       tx_tag,
  input logic             tx_sof,
  input logic [IDX_W-1:0] tx_widx
);
  localparam logic [IDX_W-1:0] W_LAST   = IDX_W'(FRAME_WORDS - 1);
  localparam logic [IDX_W-1:0] W_HEAD   = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_PAYEND = IDX_W'(11);
  localparam logic [IDX_W-1:0] W_TAIL   = IDX_W'(12);
  localparam logic [IDX_W-1:0] W_NOTAG  = IDX_W'(14);

  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  assert_sof_marks_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (tx_sof == (tx_widx == '0)));

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && tx_widx == W_LAST) |=> (tx_widx == '0 && tx_sof));

  assert_guard_and_pol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_guard && !tx_pol));

  assert_head_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && tx_widx < W_HEAD) |-> tx_flag);

  assert_tail_flag_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && tx_widx >= W_TAIL) |-> !tx_flag);

  assert_tag_anchor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && (tx_widx == '0 || tx_widx >= W_NOTAG)) |-> (tx_tag == 4'b0000));

  assert_ready_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |=> (tx_flag && tx_widx >= W_HEAD && tx_widx <= W_PAYEND));
endmodule

bind trig_frame_tx trig_frame_tx_chk #(.FRAME_WORDS(FRAME_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pay_ready(pay_ready),
  .tx_guard(tx_word[17]), .tx_pol(tx_word[0]), .tx_flag(tx_word[13]),
  .tx_tag(tx_word[12:9]), .tx_sof(tx_sof), .tx_widx(tx_widx)
);

// File: tb/trig_frame_tx_test.sv
`timescale 1ns/1ps
module trig_frame_tx_test;
  localparam int F   = 20;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_stb, dsd_stb, disc_in, pileup_in, fault_in, pay_valid;
  logic [7:0] id_byte, bufcnt_byte, status_byte, fill_byte, pay_data;
  logic       pay_ready;
  logic [17:0] tx_word;
  logic       tx_sof;
  logic [4:0] tx_widx;

  logic [7:0] pay_cnt;
  assign pay_data = pay_cnt ^ 8'h5A;

  always #10 clk = ~clk;

  trig_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .sync_stb(sync_stb), .dsd_stb(dsd_stb),
    .disc_in(disc_in), .pileup_in(pileup_in), .fault_in(fault_in),
    .id_byte(id_byte), .bufcnt_byte(bufcnt_byte), .status_byte(status_byte),
    .fill_byte(fill_byte), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_data(pay_data), .tx_word(tx_word), .tx_sof(tx_sof), .tx_widx(tx_widx)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int pv_mode = 0;

  int gtab [0:13] = '{0, 2, 3, 11, 9, 13, 15, 14, 6, 7, 5, 4, 12, 8};

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model (behavioural, per edge) ----------------
  int  m_next, ecyc, m_last;
  bit  m_slow, m_init, m_sticky, m_have;
  int  sdue[$];
  int  ddue[$];
  logic [17:0] e_word;
  bit  e_sof, e_ready;
  int  e_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_next = 0; m_slow = 0; m_init = 1; m_sticky = 0; m_have = 0; m_last = 0;
      ecyc = 0; sdue.delete(); ddue.delete();
      e_word = '0; e_sof = 0; e_idx = 0; e_ready = 0;
      pay_cnt <= 8'd0;
    end else begin : step
      bit rs, rd, slow, flag, errb, rs2, rd2, slow2;
      int idx, idx2;
      logic [7:0] sb;
      rs = (sdue.size() > 0 && sdue[0] == ecyc);
      rd = (ddue.size() > 0 && ddue[0] == ecyc);
      if (rs) void'(sdue.pop_front());
      if (rd) void'(ddue.pop_front());
      idx  = (rs || rd) ? 0 : m_next;
      slow = (rs || rd) ? (rd && !rs) : ((idx == 0) ? 1'b0 : m_slow);
      errb = fault_in | m_sticky | (m_init & !rs);
      if (idx == 0)      begin flag = 1; sb = id_byte; end
      else if (idx == 1) begin flag = 1; sb = bufcnt_byte; end
      else if (idx == 2) begin flag = 1; sb = status_byte; end
      else if (slow && idx >= 3 && idx <= 11) begin
        flag = 1;
        sb = pay_valid ? pay_data : 8'h00;
        if (pay_valid) pay_cnt <= pay_cnt + 8'd1;
      end else begin flag = 0; sb = fill_byte; end
      e_word = {1'b0, disc_in, errb, pileup_in, flag,
                (idx < 14) ? 4'(gtab[idx]) : 4'b0000, sb, 1'b0};
      e_sof = (idx == 0);
      e_idx = idx;
      m_next = (idx + 1) % F;
      m_slow = slow;
      if (rs) m_init = 0;
      if (dsd_stb) begin
        if (!(sync_stb || (m_have && ((ecyc - m_last) % F == 0)))) m_sticky = 1;
        ddue.push_back(ecyc + LAT);
      end
      if (sync_stb) begin
        m_have = 1; m_last = ecyc; sdue.push_back(ecyc + LAT);
      end
      ecyc++;
      rs2 = (sdue.size() > 0 && sdue[0] == ecyc);
      rd2 = (ddue.size() > 0 && ddue[0] == ecyc);
      idx2  = (rs2 || rd2) ? 0 : m_next;
      slow2 = (rs2 || rd2) ? (rd2 && !rs2) : ((idx2 == 0) ? 1'b0 : m_slow);
      e_ready = slow2 && idx2 >= 3 && idx2 <= 11;
    end
  end

  // ---------------- per-cycle comparison, away from the edge ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin : cmp_all
      string ftag;
      cmp("R2", "word index", 32'(tx_widx), 32'(e_idx));
      cmp("R2", "frame start", 32'(tx_sof), 32'(e_sof));
      cmp("R2", "guard/pol bits", {30'b0, tx_word[17], tx_word[0]}, 32'b0);
      cmp("R3", "word tag", 32'(tx_word[12:9]), 32'(e_word[12:9]));
      cmp("R4", "disc/pileup", {30'b0, tx_word[16], tx_word[14]},
          {30'b0, e_word[16], e_word[14]});
      cmp("R11", "error bit", 32'(tx_word[15]), 32'(e_word[15]));
      if (e_idx < 3) ftag = "R5";
      else if (e_idx <= 11 && e_word[13]) ftag = "R6";
      else ftag = "R7";
      cmp(ftag, "flag+slow byte", 32'(tx_word[13:1]), 32'(e_word[13:1]));
      cmp("R6", "pay_ready", 32'(pay_ready), 32'(e_ready));
    end
  end

  // ---------------- background stimulus ----------------
  always @(negedge clk) begin
    disc_in     = 1'($urandom);
    pileup_in   = 1'($urandom);
    id_byte     = 8'($urandom);
    bufcnt_byte = 8'($urandom);
    status_byte = 8'($urandom);
    fill_byte   = 8'($urandom);
    pay_valid   = (pv_mode == 1) ? 1'b1 : (pv_mode == 2) ? 1'($urandom) : 1'b0;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit s, input bit d);
    sync_stb = s; dsd_stb = d;
    @(negedge clk);
    sync_stb = 0; dsd_stb = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; sync_stb = 0; dsd_stb = 0; fault_in = 0;
    tick(4);
    // R1: state held during reset
    cmp("R1", "tx_word in reset", 32'(tx_word), 32'd0);
    cmp("R1", "tx_sof in reset", 32'(tx_sof), 32'd0);
    cmp("R1", "tx_widx in reset", 32'(tx_widx), 32'd0);
    cmp("R1", "pay_ready in reset", 32'(pay_ready), 32'd0);
    rst_n = 1;
    tick(40);
    // R9: power-up error held before any Sync
    cmp("R9", "error before sync", 32'(tx_word[15]), 32'd1);

    // negedge S
    strobe(1, 0);
    tick(5);
    cmp("R8", "sof 5 edges after sync", 32'(tx_sof), 32'd1);
    cmp("R8", "index after sync", 32'(tx_widx), 32'd0);
    cmp("R9", "error cleared by sync frame", 32'(tx_word[15]), 32'd0);
    tick(94);
    pv_mode = 1;
    strobe(0, 1);                 // S+100, in time
    tick(5);
    cmp("R8", "sof after demand", 32'(tx_sof), 32'd1);
    tick(3);
    cmp("R6", "payload flag idx3", 32'(tx_word[13]), 32'd1);
    cmp("R6", "first payload byte", 32'(tx_word[8:1]), 32'h5A);
    cmp("R10", "in-time demand leaves error low", 32'(tx_word[15]), 32'd0);
    tick(91);
    pv_mode = 0;
    strobe(0, 1);                 // S+200, no payload offered
    tick(8);
    cmp("R6", "empty payload flag", 32'(tx_word[13]), 32'd1);
    cmp("R6", "empty payload byte", 32'(tx_word[8:1]), 32'h00);
    tick(91);
    pv_mode = 2;
    strobe(0, 1);                 // S+300, bursty source
    tick(49);
    fault_in = 1;                 // R11
    tick(3);
    fault_in = 0;
    tick(47);
    pv_mode = 1;
    strobe(1, 1);                 // S+400, coincident: Sync rules
    tick(6);
    strobe(0, 1);                 // S+407, out of time
    tick(1);
    cmp("R8", "coincident strobes give index 3", 32'(tx_widx), 32'd3);
    cmp("R8", "coincident strobes: no payload flag", 32'(tx_word[13]), 32'd0);
    cmp("R10", "late demand raises error", 32'(tx_word[15]), 32'd1);
    tick(40);
    cmp("R10", "error stays set", 32'(tx_word[15]), 32'd1);

    rst_n = 0;
    tick(3);
    cmp("R1", "word cleared by reset", 32'(tx_word), 32'd0);
    rst_n = 1;
    strobe(0, 1);                 // demand before any Sync
    tick(30);
    cmp("R10", "demand before sync raises error", 32'(tx_word[15]), 32'd1);
    strobe(1, 0);
    tick(20);
    cmp("R10", "sync does not clear late error", 32'(tx_word[15]), 32'd1);
    tick(100);
    finish_run();
  end
endmodule